// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C master. It pulls the open-drain SCL line low or lets it go, and watches the line level through a two-flop synchronizer. A phase counter starts only when the level it belongs to is actually seen on the synchronized line. A slave that stretches the clock, slow pull-up rise times and the synchronizer latency therefore all lengthen the period. No correction is applied for any of them.

The low phase and the high phase each have their own 8-bit divider. A shared 3-bit prescaler multiplies both. At the start of every counted low phase the block emits a one-cycle strobe that tells a byte engine data may change. At the start of every counted high phase it emits another strobe that marks the sampling point. The clock runs only while master operation is enabled and slave operation is switched off. Otherwise the line is released and the block sits idle.

Top module: `i2c_scl_gen`

## Requirements
- R1: During and straight after reset, `scl_oe_o`, `low_tick_o` and `high_tick_o` are all 0.
- R2: With an ideal line (the level follows `scl_oe_o` at once, no stretching), `scl_oe_o` stays 1 for exactly `low_div_i * 2^prescale_i + 4` clock cycles per low phase. This includes the first low phase after enabling.
- R3: With an ideal line, `scl_oe_o` stays 0 for exactly `high_div_i * 2^prescale_i + 4` clock cycles per high phase.
- R4: `low_tick_o` pulses for one cycle exactly once per low phase, in the 4th cycle in which `scl_oe_o` is 1. It is only ever 1 while `scl_oe_o` is 1, and only after the synchronized line was seen low.
- R5: `high_tick_o` pulses for one cycle exactly once per high phase, in the 4th cycle of the released phase when the line is ideal. It is only ever 1 while `scl_oe_o` is 0.
- R6: If the line is held low for S cycles after release, the high phase does not count during the hold. The released phase lasts S + `high_div_i * 2^prescale_i` + 4 cycles, and `high_tick_o` moves to cycle S+4.
- R7: Whenever `master_en_i` is 0 or `slave_off_i` is 0, `scl_oe_o` and both strobes are 0 from the next cycle on, and nothing toggles.
- R8: `low_tick_o` and `high_tick_o` are never 1 in the same cycle.
- R9: A divider of 0 gives the minimum phase of 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Master operation enable |
| slave_off_i | input | 1 | 1 when slave operation is disabled |
| prescale_i | input | 3 | Shared prescaler exponent for both phases |
| high_div_i | input | 8 | High-phase divider |
| low_div_i | input | 8 | Low-phase divider |
| scl_i | input | 1 | Raw SCL pin level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| low_tick_o | output | 1 | One-cycle strobe at the start of a counted low phase |
| high_tick_o | output | 1 | One-cycle strobe at the start of a counted high phase |

## Verification
A wrong phase state or counter value shows up at the pin as a shortened or stretched `scl_oe_o` level. It becomes visible within one phase, i.e. no later than `div * 2^prescale + 4` cycles after the fault. A wait state that counted when it should not would show as a released phase that does not grow with the stretch length, and as a `high_tick_o` arriving before the line is seen high. Misplaced strobes are caught by their position inside each measured phase and by counting them per phase.

// File: rtl/i2c_scl_pkg.sv
`timescale 1ns/1ps
package i2c_scl_pkg;
  localparam int unsigned PRE_W = 3;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned CNT_W = DIV_W + (1 << PRE_W) - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LWAIT,
    ST_LCNT,
    ST_HWAIT,
    ST_HCNT
  } scl_state_e;
endpackage

// File: rtl/scl_sync.sv
`timescale 1ns/1ps
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  // bus idles high, so the chain resets to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/scl_phase_cnt.sv
`timescale 1ns/1ps
module scl_phase_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i && !clr_i |-> !zero_o);
endmodule

// File: rtl/i2c_scl_gen.sv
`timescale 1ns/1ps
module i2c_scl_gen
  import i2c_scl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_en_i,
  input  logic             slave_off_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [DIV_W-1:0] high_div_i,
  input  logic [DIV_W-1:0] low_div_i,
  input  logic             scl_i,
  output logic             scl_oe_o,
  output logic             low_tick_o,
  output logic             high_tick_o
);
  scl_state_e       st_q, st_d;
  logic             run;
  logic             scl_s;
  logic             cnt_zero, cnt_load, cnt_dec;
  logic [CNT_W-1:0] cnt_val;
  logic             low_tick_q, high_tick_q;

  assign run = master_en_i & slave_off_i;

  scl_sync #(.STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  scl_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!run),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .dec_i     (cnt_dec),
    .zero_o    (cnt_zero)
  );

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = '0;
    if (!run) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_LWAIT;
        ST_LWAIT: if (!scl_s) begin   // low level seen: start counting
          st_d     = ST_LCNT;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(low_div_i) << prescale_i;
        end
        ST_LCNT: if (cnt_zero) st_d = ST_HWAIT;
                 else          cnt_dec = 1'b1;
        ST_HWAIT: if (scl_s) begin    // stays here while stretched
          st_d     = ST_HCNT;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(high_div_i) << prescale_i;
        end
        ST_HCNT: if (cnt_zero) st_d = ST_LWAIT;
                 else          cnt_dec = 1'b1;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      low_tick_q  <= 1'b0;
      high_tick_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      low_tick_q  <= (st_q == ST_LWAIT) && (st_d == ST_LCNT);
      high_tick_q <= (st_q == ST_HWAIT) && (st_d == ST_HCNT);
    end
  end

  assign scl_oe_o    = (st_q == ST_LWAIT) || (st_q == ST_LCNT);
  assign low_tick_o  = low_tick_q;
  assign high_tick_o = high_tick_q;

  p_tick_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_tick_o && high_tick_o));
  p_low_tick_driven_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_tick_o |-> scl_oe_o);
  p_low_tick_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_tick_o |-> !$past(scl_s));
  p_high_tick_rel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_tick_o |-> !scl_oe_o);
  p_high_after_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_tick_o |-> $past(scl_s));
  p_idle_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !scl_oe_o && !low_tick_o && !high_tick_o);
endmodule

// File: tb/test_i2c_scl_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_gen;
  typedef struct packed {
    logic [2:0] p;
    logic [7:0] h;
    logic [7:0] l;
    int         exp_lo;
    int         exp_hi;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 8'd1,  8'd1,    5,   5},
    '{3'd0, 8'd3,  8'd7,   11,   7},
    '{3'd2, 8'd2,  8'd5,   24,  12},
    '{3'd1, 8'd0,  8'd4,   12,   4},
    '{3'd3, 8'd10, 8'd6,   52,  84},
    '{3'd7, 8'd1,  8'd2,  260, 132}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_en = 1'b0;
  logic       s_off = 1'b1;
  logic [2:0] pre = '0;
  logic [7:0] hdiv = '0;
  logic [7:0] ldiv = '0;
  logic       stretch = 1'b0;
  logic       scl_oe, ltick, htick;
  logic       scl_pin;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  assign scl_pin = !(scl_oe || stretch);

  always #2.5 clk = ~clk;

  i2c_scl_gen i_i2c_scl_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .master_en_i(m_en),
    .slave_off_i(s_off),
    .prescale_i (pre),
    .high_div_i (hdiv),
    .low_div_i  (ldiv),
    .scl_i      (scl_pin),
    .scl_oe_o   (scl_oe),
    .low_tick_o (ltick),
    .high_tick_o(htick)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  // measures one low phase then one high phase; called at a negedge
  task automatic measure(input int s, output int lo_len, output int lo_pos, output int lo_cnt,
                         output int hi_len, output int hi_pos, output int hi_cnt);
    lo_len = 0; lo_pos = 0; lo_cnt = 0;
    hi_len = 0; hi_pos = 0; hi_cnt = 0;
    while (!scl_oe) @(negedge clk);
    while (scl_oe) begin
      lo_len++;
      if (ltick) begin lo_cnt++; lo_pos = lo_len; end
      if (htick) hi_cnt++;
      @(negedge clk);
    end
    while (!scl_oe) begin
      hi_len++;
      if (hi_len == 1) stretch = 1'b1;
      if (hi_len == s + 1) stretch = 1'b0;
      if (htick) begin hi_cnt++; hi_pos = hi_len; end
      if (ltick) lo_cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lo_len, lo_pos, lo_cnt, hi_len, hi_pos, hi_cnt;
    int bad;

    repeat (3) @(negedge clk);
    check(int'(scl_oe), 0, "R1", "oe in reset");
    check(int'(ltick | htick), 0, "R1", "ticks in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(scl_oe), 0, "R1", "oe after reset");

    // vector walk: first low and high phase after each enable
    for (int i = 0; i < NVEC; i++) begin
      pre = VEC[i].p; hdiv = VEC[i].h; ldiv = VEC[i].l;
      m_en = 1'b1;
      @(negedge clk);
      measure(0, lo_len, lo_pos, lo_cnt, hi_len, hi_pos, hi_cnt);
      check(lo_len, VEC[i].exp_lo, "R2", $sformatf("low length vec %0d", i));
      check(hi_len, VEC[i].exp_hi, "R3", $sformatf("high length vec %0d", i));
      check(lo_pos, 4, "R4", $sformatf("low tick position vec %0d", i));
      check(lo_cnt, 1, "R4", $sformatf("low tick count vec %0d", i));
      check(hi_pos, 4, "R5", $sformatf("high tick position vec %0d", i));
      check(hi_cnt, 1, "R5", $sformatf("high tick count vec %0d", i));
      if (VEC[i].h == 8'd0) check(hi_len, 4, "R9", "zero divider minimum");
      m_en = 1'b0;
      repeat (3) @(negedge clk);
    end

    // steady state: second pair of phases, enable kept on
    pre = 3'd1; hdiv = 8'd3; ldiv = 8'd2;
    m_en = 1'b1;
    @(negedge clk);
    measure(0, lo_len, lo_pos, lo_cnt, hi_len, hi_pos, hi_cnt);
    measure(0, lo_len, lo_pos, lo_cnt, hi_len, hi_pos, hi_cnt);
    check(lo_len, 8, "R2", "second low phase");
    check(hi_len, 10, "R3", "second high phase");

    // clock stretching during the high phase
    measure(7, lo_len, lo_pos, lo_cnt, hi_len, hi_pos, hi_cnt);
    check(hi_len, 7 + 10, "R6", "stretched high length");
    check(hi_pos, 7 + 4, "R6", "stretched high tick position");
    check(hi_cnt, 1, "R6", "one high tick when stretched");
    check(lo_len, 8, "R2", "low before stretch");

    // disable mid low phase
    while (!scl_oe) @(negedge clk);
    repeat (3) @(negedge clk);
    m_en = 1'b0;
    @(negedge clk);
    check(int'(scl_oe), 0, "R7", "oe released after master disable");
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (scl_oe || ltick || htick) bad++;
    end
    check(bad, 0, "R7", "activity while master disabled");

    // slave operation left on blocks the clock
    m_en = 1'b1; s_off = 1'b0;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (scl_oe || ltick || htick) bad++;
    end
    check(bad, 0, "R7", "activity while slave not disabled");
    s_off = 1'b1;
    @(negedge clk);
    check(int'(scl_oe), 1, "R7", "clock resumes on slave disable");
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (ltick && htick) bad++;
    end
    check(bad, 0, "R8", "simultaneous ticks");

    // reset mid phase
    rst_n = 1'b0;
    @(negedge clk);
    check(int'(scl_oe | ltick | htick), 0, "R1", "outputs in mid-run reset");
    finish_run();
  end
endmodule